// File: doc/BRIEF.md
# Binary32 Rounding and Packing Stage

This block is the last stage of a single-precision floating-point unit. An arithmetic datapath hands it an unrounded result: a sign, an unbiased exponent in two's complement whose range is wider than binary32's, and a normalized significand with extra low-order bits and a separate sticky bit. The block rounds that value under one of five rounding modes and encodes it as an IEEE-754 binary32 word. This includes subnormal encoding, carries into the next binade, and saturation on overflow. It also produces the five exception flags.

Underflow uses after-rounding tininess. The rounding used for this test limits precision to 24 bits only and keeps the exponent range unbounded. It is kept separate from the rounding that actually builds the subnormal encoding. A value that starts below the smallest normal can therefore encode as exactly ±2^-126 and still raise underflow. Underflow is skipped only when rounding at 24-bit precision alone already reaches 2^-126.

Input value: (-1)^inSign × (inSig / 2^(SIG_W-1)) × 2^inExp. The most significant bit of inSig is set for every non-zero input. A parameter adds one register stage on the outputs.

Top module: `rp32_round`

## Requirements
- R1: Under mode code 0 (nearest, ties to even), the result is rounded to the nearer 24-bit significand, and exact ties go to an even last bit. The guard bit is the first bit below the 24 kept bits. The sticky bit is the OR of all lower bits and inSticky.
- R2: Mode codes select the other roundings: 1 truncates toward zero, 2 rounds toward minus infinity, 3 toward plus infinity, 4 to nearest with ties away from zero. Codes 5 to 7 behave as code 0.
- R3: A normal result whose significand carries out during rounding has its biased exponent raised by one. When the biased exponent (inExp+127) is below 1, the exponent field is 0 and the significand is shifted right by 1-(inExp+127) before rounding. A subnormal that rounds up into bit 23 encodes with exponent field 1.
- R4: Underflow (flag bit 1) is raised with inexact (bit 0) when a non-zero inexact result lies below 2^-126 after rounding to 24 bits at unbounded exponent. This applies even when the encoded result is 0x00800000 or 0x80800000.
- R5: When rounding to 24 bits at unbounded exponent already gives exactly 2^-126, only inexact is raised. Under round toward zero a subnormal input never encodes as a normal.
- R6: Underflow is never raised without inexact. An exactly representable subnormal raises no flag.
- R7: A rounded biased exponent of 255 or more raises overflow (bit 2) and inexact. The result is infinity (0x7F800000 with sign) or the largest finite value (0x7F7FFFFF with sign), chosen by mode and sign. Exponent 254 with an all-ones significand is exact and raises nothing.
- R8: A zero significand produces a zero of the input sign with no flags. Every result keeps the input sign.
- R9: The flag vector is {invalid, divide-by-zero, overflow, underflow, inexact}, from bit 4 down to bit 0. This stage always drives invalid and divide-by-zero as 0.
- R10: With REG_OUT=1 each result appears one clock after its input, and reset clears the outputs to 0. With REG_OUT=0 the stage is combinational.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output register |
| rstN | input | 1 | Asynchronous active-low reset |
| inSign | input | 1 | Sign of the unrounded value |
| inExp | input | EXP_W | Unbiased exponent, two's complement |
| inSig | input | SIG_W | Normalized significand, MSB weight 2^0 |
| inSticky | input | 1 | OR of discarded bits below inSig |
| rndMode | input | 3 | Rounding mode code |
| outBits | output | 32 | Encoded binary32 result |
| outFlags | output | 5 | {invalid, div-by-zero, overflow, underflow, inexact} |

## Verification
The bench targets the smallest-normal boundary from both sides. A design that tests tininess on the encoded result drops underflow for 0x00800000 and 0x80800000 under nearest-even and toward minus infinity. A design that tests tininess before rounding raises underflow when 24-bit rounding alone already carries to 2^-126. Other cases cover ties that must stay even or go away from zero, a half-ULP value below the smallest subnormal, and carries into the next binade and into overflow. A wrong mode table then shows up as the wrong saturation value, a misplaced guard bit as an off-by-one significand, and a missing sticky path as a lost directed round-up.

// File: rtl/rp32_pkg.sv
package rp32_pkg;
  localparam int MANT_W  = 24;
  localparam int FRAC_W  = 23;
  localparam int BIAS    = 127;
  localparam int EXP_INF = 255;
  localparam int SH_W    = 8;

  typedef enum logic [2:0] {
    RM_RNE = 3'd0,
    RM_RTZ = 3'd1,
    RM_RDN = 3'd2,
    RM_RUP = 3'd3,
    RM_RMM = 3'd4
  } rmode_e;

  // strobes from control to datapath
  typedef struct packed {
    logic            isZero;
    logic            isSub;
    logic            tiny;
    logic [SH_W-1:0] shAmt;
  } rp32_strb_t;

  function automatic logic roundInc(input logic [2:0] mode, input logic sgn,
                                    input logic lsb, input logic grd, input logic stk);
    case (mode)
      RM_RTZ:  return 1'b0;
      RM_RDN:  return sgn & (grd | stk);
      RM_RUP:  return ~sgn & (grd | stk);
      RM_RMM:  return grd;
      default: return grd & (stk | lsb);
    endcase
  endfunction
endpackage

// File: rtl/rp32_ctrl.sv
module rp32_ctrl
  import rp32_pkg::*;
#(
  parameter int EXP_W = 10,
  parameter int SIG_W = 27
) (
  input  logic               inSign,
  input  logic [EXP_W-1:0]   inExp,
  input  logic [SIG_W-1:0]   inSig,
  input  logic               inSticky,
  input  logic [2:0]         rndMode,
  output logic [EXP_W+1:0]   biasedExp,
  output rp32_strb_t         strb
);
  localparam int BE_W   = EXP_W + 2;
  localparam int SH_CAP = SIG_W + 1;

  logic [BE_W-1:0]   rawSh;
  logic [MANT_W-1:0] keepU;
  logic              grdU, stkU, carryU, subNow;

  always_comb begin
    biasedExp = {{2{inExp[EXP_W-1]}}, inExp} + BE_W'(BIAS);
    subNow    = biasedExp[BE_W-1] | (biasedExp == '0);
    rawSh     = BE_W'(1) - biasedExp;
    // rounding at 24-bit precision with the exponent left unbounded
    keepU  = inSig[SIG_W-1 -: MANT_W];
    grdU   = inSig[SIG_W-1-MANT_W];
    stkU   = (|inSig[SIG_W-2-MANT_W:0]) | inSticky;
    carryU = (&keepU) & roundInc(rndMode, inSign, keepU[0], grdU, stkU);

    strb.isZero = (inSig == '0);
    strb.isSub  = subNow;
    strb.tiny   = subNow & ~((biasedExp == '0) & carryU);
    if (!subNow)
      strb.shAmt = '0;
    else if (rawSh > BE_W'(SH_CAP))
      strb.shAmt = SH_W'(SH_CAP);
    else
      strb.shAmt = SH_W'(rawSh);
  end
endmodule

// File: rtl/rp32_dp.sv
module rp32_dp
  import rp32_pkg::*;
#(
  parameter int EXP_W = 10,
  parameter int SIG_W = 27
) (
  input  logic               inSign,
  input  logic [SIG_W-1:0]   inSig,
  input  logic               inSticky,
  input  logic [2:0]         rndMode,
  input  logic [EXP_W+1:0]   biasedExp,
  input  rp32_strb_t         strb,
  output logic [31:0]        resBits,
  output logic [4:0]         resFlags
);
  localparam int BE_W   = EXP_W + 2;
  localparam int WIDE   = 2 * SIG_W + 2;
  localparam int GRD_AT = WIDE - 1 - MANT_W;

  logic [WIDE-1:0]   wide;
  logic [MANT_W-1:0] keep;
  logic [MANT_W:0]   rounded;
  logic [BE_W-1:0]   expN;
  logic              grd, stk, inc, inexact, ovf, toInf;

  always_comb begin
    wide    = {inSig, {(SIG_W + 2){1'b0}}} >> strb.shAmt;
    keep    = wide[WIDE-1 -: MANT_W];
    grd     = wide[GRD_AT];
    stk     = (|wide[GRD_AT-1:0]) | inSticky;
    inc     = roundInc(rndMode, inSign, keep[0], grd, stk);
    rounded = {1'b0, keep} + {{MANT_W{1'b0}}, inc};
    inexact = grd | stk;
    expN    = biasedExp + {{(BE_W - 1){1'b0}}, rounded[MANT_W]};
    ovf     = ~strb.isSub & ~expN[BE_W-1] & (expN >= BE_W'(EXP_INF));
    case (rndMode)
      RM_RTZ:  toInf = 1'b0;
      RM_RDN:  toInf = inSign;
      RM_RUP:  toInf = ~inSign;
      default: toInf = 1'b1;
    endcase

    resBits  = {inSign, 31'd0};
    resFlags = '0;
    if (strb.isZero) begin
      resBits = {inSign, 31'd0};
    end else if (strb.isSub) begin
      resBits  = {inSign, 7'd0, rounded[FRAC_W], rounded[FRAC_W-1:0]};
      resFlags = {3'b000, strb.tiny & inexact, inexact};
    end else if (ovf) begin
      resBits  = toInf ? {inSign, 8'hFF, {FRAC_W{1'b0}}}
                       : {inSign, 8'hFE, {FRAC_W{1'b1}}};
      resFlags = 5'b00101;
    end else begin
      resBits  = {inSign, expN[7:0], rounded[FRAC_W-1:0]};
      resFlags = {4'b0000, inexact};
    end
  end
endmodule

// File: rtl/rp32_round.sv
module rp32_round
  import rp32_pkg::*;
#(
  parameter int EXP_W   = 10,
  parameter int SIG_W   = 27,
  parameter bit REG_OUT = 1'b1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             inSign,
  input  logic [EXP_W-1:0] inExp,
  input  logic [SIG_W-1:0] inSig,
  input  logic             inSticky,
  input  logic [2:0]       rndMode,
  output logic [31:0]      outBits,
  output logic [4:0]       outFlags
);
  logic [EXP_W+1:0] biasedExp;
  rp32_strb_t       strb;
  logic [31:0]      resBits;
  logic [4:0]       resFlags;

  rp32_ctrl #(.EXP_W(EXP_W), .SIG_W(SIG_W)) u_ctrl (
    .inSign(inSign), .inExp(inExp), .inSig(inSig), .inSticky(inSticky),
    .rndMode(rndMode), .biasedExp(biasedExp), .strb(strb)
  );

  rp32_dp #(.EXP_W(EXP_W), .SIG_W(SIG_W)) u_dp (
    .inSign(inSign), .inSig(inSig), .inSticky(inSticky), .rndMode(rndMode),
    .biasedExp(biasedExp), .strb(strb), .resBits(resBits), .resFlags(resFlags)
  );

  generate
    if (REG_OUT) begin : g_reg
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          outBits  <= '0;
          outFlags <= '0;
        end else begin
          outBits  <= resBits;
          outFlags <= resFlags;
        end
      end
    end else begin : g_comb
      always_comb begin
        outBits  = resBits;
        outFlags = resFlags;
      end
    end
  endgenerate
endmodule

// File: rtl/rp32_round_chk.sv
module rp32_round_chk
  import rp32_pkg::*;
#(
  parameter int EXP_W   = 10,
  parameter int SIG_W   = 27,
  parameter bit REG_OUT = 1'b1
) (
  input logic             clk,
  input logic             rstN,
  input logic             inSign,
  input logic [SIG_W-1:0] inSig,
  input logic [2:0]       rndMode,
  input logic [31:0]      outBits,
  input logic [4:0]       outFlags
);
  logic       dValid, dSign, dZero;
  logic [2:0] dMode;

  generate
    if (REG_OUT) begin : g_d
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          dValid <= 1'b0; dSign <= 1'b0; dZero <= 1'b0; dMode <= '0;
        end else begin
          dValid <= 1'b1; dSign <= inSign; dZero <= (inSig == '0); dMode <= rndMode;
        end
      end
    end else begin : g_c
      always_comb begin
        dValid = 1'b1; dSign = inSign; dZero = (inSig == '0); dMode = rndMode;
      end
    end
  endgenerate

  AST_UF_WITH_NX: assert property (@(posedge clk) disable iff (!rstN)
    outFlags[1] |-> outFlags[0]); // R6
  AST_UF_NEAR_MIN: assert property (@(posedge clk) disable iff (!rstN)
    outFlags[1] |-> (outBits[30:23] <= 8'd1)); // R4
  AST_OF_WITH_NX: assert property (@(posedge clk) disable iff (!rstN)
    outFlags[2] |-> (outFlags[0] && outBits[30:23] >= 8'hFE)); // R7
  AST_RTZ_FINITE: assert property (@(posedge clk) disable iff (!rstN)
    (dValid && dMode == RM_RTZ) |-> (outBits[30:23] != 8'hFF)); // R7
  AST_NO_NV_DZ: assert property (@(posedge clk) disable iff (!rstN)
    outFlags[4:3] == 2'b00); // R9
  AST_SIGN_KEPT: assert property (@(posedge clk) disable iff (!rstN)
    dValid |-> (outBits[31] == dSign)); // R8
  AST_ZERO_CLEAN: assert property (@(posedge clk) disable iff (!rstN)
    (dValid && dZero) |-> (outBits[30:0] == '0 && outFlags == '0)); // R8
endmodule

bind rp32_round rp32_round_chk #(.EXP_W(EXP_W), .SIG_W(SIG_W), .REG_OUT(REG_OUT)) u_chk (
  .clk(clk), .rstN(rstN), .inSign(inSign), .inSig(inSig), .rndMode(rndMode),
  .outBits(outBits), .outFlags(outFlags)
);

// File: tb/rp32_round_bench.sv
`timescale 1ns/1ps
module rp32_round_bench;
  import rp32_pkg::*;
  localparam int EXP_W = 10;
  localparam int SIG_W = 27;

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic             inSign = 1'b0;
  logic [EXP_W-1:0] inExp = '0;
  logic [SIG_W-1:0] inSig = '0;
  logic             inSticky = 1'b0;
  logic [2:0]       rndMode = '0;
  logic [31:0]      outBits;
  logic [4:0]       outFlags;

  int total = 0;
  int bad = 0;
  int cyc = 0;
  bit finished = 1'b0;

  typedef struct packed {
    logic [31:0] b;
    logic [4:0]  f;
    logic [31:0] due;
  } item_t;
  item_t expQ[$];
  string tagQ[$];

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  rp32_round #(.EXP_W(EXP_W), .SIG_W(SIG_W), .REG_OUT(1'b1)) u_rp32_round (
    .clk(clk), .rstN(rstN), .inSign(inSign), .inExp(inExp), .inSig(inSig),
    .inSticky(inSticky), .rndMode(rndMode), .outBits(outBits), .outFlags(outFlags)
  );

  task automatic drive(input logic s, input int e, input logic [23:0] mant,
                       input logic [2:0] tail, input logic stk, input rmode_e m,
                       input logic [31:0] eb, input logic [4:0] ef, input string tag);
    item_t it;
    @(posedge clk);
    #2;
    inSign = s; inExp = EXP_W'(e); inSig = {mant, tail}; inSticky = stk; rndMode = m;
    it.b = eb; it.f = ef; it.due = 32'(cyc + 1);
    expQ.push_back(it);
    tagQ.push_back(tag);
  endtask

  // monitor: pop and compare when a result is due
  always @(negedge clk) begin
    if (expQ.size() > 0 && expQ[0].due == 32'(cyc)) begin
      item_t it;
      string tg;
      it = expQ.pop_front();
      tg = tagQ.pop_front();
      total++;
      if (outBits !== it.b || outFlags !== it.f) begin
        bad++;
        $display("FAIL %s: got bits=%h flags=%b expected bits=%h flags=%b",
                 tg, outBits, outFlags, it.b, it.f);
      end
    end
  end

  initial begin
    #(20 * 4000);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog: got hang expected completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    total++;
    if (outBits !== 32'd0 || outFlags !== 5'd0) begin
      bad++;
      $display("FAIL R10 reset: got bits=%h flags=%b expected 0/0", outBits, outFlags);
    end
    @(posedge clk); #2; rstN = 1'b1;

    // R1 nearest even
    drive(0, 0, 24'h800000, 3'b000, 0, RM_RNE, 32'h3F800000, 5'b00000, "R1 exact one");
    drive(0, 0, 24'h800000, 3'b100, 0, RM_RNE, 32'h3F800000, 5'b00001, "R1 tie stays even");
    drive(0, 0, 24'h800001, 3'b100, 0, RM_RNE, 32'h3F800002, 5'b00001, "R1 tie rounds to even");
    drive(0, 0, 24'h800000, 3'b000, 1, RM_RUP, 32'h3F800001, 5'b00001, "R1 sticky input");
    // R2 directed modes
    drive(0, 0, 24'h800000, 3'b001, 0, RM_RUP, 32'h3F800001, 5'b00001, "R2 up positive");
    drive(1, 0, 24'h800000, 3'b001, 0, RM_RUP, 32'hBF800000, 5'b00001, "R2 up negative");
    drive(1, 0, 24'h800000, 3'b001, 0, RM_RDN, 32'hBF800001, 5'b00001, "R2 down negative");
    drive(0, 0, 24'h800000, 3'b100, 0, RM_RMM, 32'h3F800001, 5'b00001, "R2 ties away");
    drive(0, 0, 24'hFFFFFF, 3'b111, 0, RM_RTZ, 32'h3FFFFFFF, 5'b00001, "R2 truncate");
    // R3 carries and subnormals
    drive(0, 0, 24'hFFFFFF, 3'b100, 0, RM_RNE, 32'h40000000, 5'b00001, "R3 binade carry");
    drive(0, -127, 24'h800000, 3'b000, 0, RM_RNE, 32'h00400000, 5'b00000, "R3 R6 exact subnormal");
    drive(0, -140, 24'h800000, 3'b000, 0, RM_RNE, 32'h00000200, 5'b00000, "R3 deep subnormal");
    drive(0, -127, 24'h800001, 3'b000, 0, RM_RNE, 32'h00400000, 5'b00011, "R3 R6 inexact subnormal");
    drive(0, -150, 24'h800000, 3'b000, 0, RM_RNE, 32'h00000000, 5'b00011, "R3 half ulp to zero");
    drive(0, -150, 24'h800000, 3'b000, 0, RM_RUP, 32'h00000001, 5'b00011, "R3 half ulp up");
    // R4 boundary with underflow
    drive(0, -127, 24'hFFFFFF, 3'b000, 0, RM_RNE, 32'h00800000, 5'b00011, "R4 boundary positive");
    drive(1, -127, 24'hFFFFFF, 3'b000, 0, RM_RNE, 32'h80800000, 5'b00011, "R4 boundary negative");
    drive(1, -127, 24'hFFFFFF, 3'b000, 0, RM_RDN, 32'h80800000, 5'b00011, "R4 boundary down");
    // R5 no underflow when 24-bit rounding reaches the normal range
    drive(0, -127, 24'hFFFFFF, 3'b100, 0, RM_RNE, 32'h00800000, 5'b00001, "R5 reaches normal");
    drive(0, -127, 24'hFFFFFF, 3'b100, 0, RM_RTZ, 32'h007FFFFF, 5'b00011, "R5 truncate stays sub");
    // R7 overflow
    drive(0, 128, 24'h800000, 3'b000, 0, RM_RNE, 32'h7F800000, 5'b00101, "R7 nearest inf");
    drive(0, 128, 24'h800000, 3'b000, 0, RM_RTZ, 32'h7F7FFFFF, 5'b00101, "R7 truncate max");
    drive(1, 128, 24'h800000, 3'b000, 0, RM_RDN, 32'hFF800000, 5'b00101, "R7 down neg inf");
    drive(1, 128, 24'h800000, 3'b000, 0, RM_RUP, 32'hFF7FFFFF, 5'b00101, "R7 up neg max");
    drive(0, 127, 24'hFFFFFF, 3'b100, 0, RM_RNE, 32'h7F800000, 5'b00101, "R7 carry overflow");
    drive(0, 127, 24'hFFFFFF, 3'b000, 0, RM_RNE, 32'h7F7FFFFF, 5'b00000, "R7 largest exact");
    // R8 zero, R9 unused flags
    drive(1, 5, 24'h000000, 3'b000, 0, RM_RNE, 32'h80000000, 5'b00000, "R8 R9 negative zero");
    drive(0, -300, 24'h000000, 3'b000, 1, RM_RUP, 32'h00000000, 5'b00000, "R8 positive zero");

    repeat (4) @(posedge clk);
    total++;
    if (expQ.size() != 0) begin
      bad++;
      $display("FAIL R10 latency: got %0d pending expected 0", expQ.size());
    end
    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule